// File: doc/BRIEF.md
# Preloadable Up/Down Counter Channel

This block is one counter channel. It holds a count register and two preload registers. A separate clock front end delivers count-up and count-down pulses. On top of those pulses the channel applies several rules. A direction bit can swap the meaning of the two pulses. Start and stop triggers gate when counting is enabled. A permission rule decides whether a preload strobe is accepted. An optional alternation between the two preload registers turns the channel into a PWM source. A down-count that reaches one reloads from the other register, so the output toggles between two durations.

All mode fields are static configuration inputs. Software and hardware preload requests arrive as one-cycle strobes. An index input supplies the edges used by the trigger modes. The channel produces the count, a registered zero flag, one-cycle overflow and underflow pulses, and an external output. The external output qualifies one of five conditions and has a selectable polarity. Every output is registered and changes on the clock edge that samples the causing input.

Top module: `tally_channel`

## Requirements
- R1: While `rst` is high, on each clock edge: `count` becomes 0, `at_zero` becomes 1, `wrap_up` and `wrap_dn` become 0, `ext_out` becomes 0, counting is disabled and preload register 0 is selected.
- R2: When `pl_zero_only`=1, a preload strobe (`sw_load` or `hw_load`, either one) is accepted only if `count` is 0. A refused strobe leaves `count` unchanged.
- R3: When `pl_zero_only`=0, any preload strobe is accepted. `count` takes the selected preload register on the next edge. The selected register is `pre1` only when `alt_en`=1 and the selector is 1; otherwise it is `pre0`. An accepted preload takes priority over a count step in the same cycle.
- R4: While counting is enabled and no preload is accepted, each cycle adds one for an effective up pulse and subtracts one for an effective down pulse, modulo 2^WIDTH. With `rev_dir`=0 the effective up pulse is `cnt_up` and the effective down pulse is `cnt_dn`; `rev_dir`=1 swaps them. When both pulses are present, the count holds.
- R5: With `alt_en`=1, an effective down step from a count of 1 does not produce 0. Instead it loads the register that is not selected and flips the selector. With `alt_en`=0 the selector is forced to 0, so only `pre0` is used.
- R6: Counting is enabled by the start code `start_sel`: 0 or 3 = the first cycle `run` is high after being low (or after reset); 1 = a rising edge of `index_in`; 2 = an accepted preload. While `run` is low, counting is disabled. The enable takes effect from the cycle after the trigger.
- R7: Counting is disabled by the stop code `stop_sel`: 0 or 3 = never; 1 = a falling edge of `index_in`; 2 = a count step that lands on 0. If a start and a stop fall in the same cycle, the stop wins.
- R8: `wrap_up` is high for exactly the one cycle after an up step from all ones to 0. `wrap_dn` is high for exactly the one cycle after a down step from 0 to all ones.
- R9: `ext_out`, before polarity, follows the code `out_sel`: 0 = inactive; 1 = high the cycle after a `snap` strobe; 2 = selector is 1; 3 = `count` nonzero; 4 = `count` zero; 5 to 7 = inactive. It is registered and aligned with `count`.
- R10: `out_inv`=1 inverts `ext_out` in every mode, including the inactive codes.
- R11: `at_zero` is 1 exactly when the registered `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Channel run enable (level) |
| rev_dir | input | 1 | Swap up and down pulses |
| pl_zero_only | input | 1 | Accept preloads only at count zero |
| alt_en | input | 1 | Alternate between the two preload registers |
| out_sel | input | 3 | External output qualification code |
| out_inv | input | 1 | External output polarity inversion |
| start_sel | input | 2 | Count-enable trigger code |
| stop_sel | input | 2 | Count-disable trigger code |
| pre0 | input | WIDTH | Preload register 0 |
| pre1 | input | WIDTH | Preload register 1 |
| cnt_up | input | 1 | Up pulse from the clock front end |
| cnt_dn | input | 1 | Down pulse from the clock front end |
| index_in | input | 1 | Index signal (edges used as triggers) |
| sw_load | input | 1 | Software preload strobe |
| hw_load | input | 1 | Hardware preload strobe |
| snap | input | 1 | One-cycle compare-snapshot strobe |
| count | output | WIDTH | Current count |
| at_zero | output | 1 | Count equals zero |
| wrap_up | output | 1 | One-cycle overflow pulse |
| wrap_dn | output | 1 | One-cycle underflow pulse |
| ext_out | output | 1 | Qualified, polarity-adjusted external output |

## Verification
The bench targets the following corner cases.
- A refused preload while the count is nonzero: a design that ignored the permission rule would reload and restart a non-retriggerable one-shot.
- The reload at a count of one under alternation: a wrong design would show a zero count, or would keep the selector and never change the PWM phase.
- Wraps in both directions: a wrong design would miss or stretch the overflow and underflow pulses.
- Reversed direction with simultaneous up and down pulses: a wrong design would drift.
- Each start and stop code, including the reserved values and a start and stop in the same cycle: a wrong design would count a cycle early, fail to stop at zero, or latch into an undefined enable state.
- Every output code under both polarities: a wrong design would misalign `ext_out` with `count` by one cycle.

// File: rtl/tally_pkg.sv
package tally_pkg;

  typedef enum logic [2:0] {
    OQ_OFF     = 3'd0,
    OQ_SNAP    = 3'd1,
    OQ_ALTSEL  = 3'd2,
    OQ_NONZERO = 3'd3,
    OQ_ZERO    = 3'd4
  } out_qual_e;

  typedef enum logic [1:0] {
    TRG_PLAIN = 2'd0,
    TRG_INDEX = 2'd1,
    TRG_EVENT = 2'd2,
    TRG_RSVD  = 2'd3
  } trig_e;

endpackage

// File: rtl/tally_edge.sv
module tally_edge #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] =  sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] &  prev_q[g];
  end

endmodule

// File: rtl/tally_gate.sv
module tally_gate
  import tally_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [1:0] start_sel_i,
  input  logic [1:0] stop_sel_i,
  input  logic       idx_rise_i,
  input  logic       idx_fall_i,
  input  logic       load_ok_i,
  input  logic       hit_zero_i,
  output logic       en_o
);

  logic run_q;
  logic en_q;
  logic start_ev;
  logic stop_ev;
  trig_e start_code;
  trig_e stop_code;

  assign start_code = trig_e'(start_sel_i);
  assign stop_code  = trig_e'(stop_sel_i);

  always_comb begin
    case (start_code)
      TRG_INDEX: start_ev = idx_rise_i;
      TRG_EVENT: start_ev = load_ok_i;
      default:   start_ev = run_i & ~run_q;
    endcase
    case (stop_code)
      TRG_INDEX: stop_ev = idx_fall_i;
      TRG_EVENT: stop_ev = hit_zero_i;
      default:   stop_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i)        en_q <= 1'b0;
      else if (stop_ev)  en_q <= 1'b0;
      else if (start_ev) en_q <= 1'b1;
    end
  end

  assign en_o = en_q;

  AST_RUN_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !en_q); // R6
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stop_sel_i == 2'd2 && hit_zero_i) |=> !en_q); // R7
  AST_STOP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (stop_sel_i == 2'd1 && idx_fall_i) |=> !en_q); // R7

endmodule

// File: rtl/tally_core.sv
module tally_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             load_req_i,
  input  logic             zero_only_i,
  input  logic             alt_i,
  input  logic [WIDTH-1:0] pre0_i,
  input  logic [WIDTH-1:0] pre1_i,
  output logic [WIDTH-1:0] count_o,
  output logic             sel_o,
  output logic [WIDTH-1:0] count_nxt_o,
  output logic             sel_nxt_o,
  output logic             load_ok_o,
  output logic             hit_zero_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             zero_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] count_q, count_d;
  logic             sel_q, sel_d;
  logic             ovf_q, unf_q, zero_q;
  logic             ovf_d, unf_d;
  logic             load_ok, step_up, step_dn, hit_zero;
  logic             is_zero;

  assign is_zero = (count_q == '0);
  assign load_ok = load_req_i & (~zero_only_i | is_zero);
  assign step_up = en_i & inc_i & ~dec_i;
  assign step_dn = en_i & dec_i & ~inc_i;

  always_comb begin
    count_d  = count_q;
    sel_d    = alt_i & sel_q;
    ovf_d    = 1'b0;
    unf_d    = 1'b0;
    hit_zero = 1'b0;
    if (load_ok) begin
      count_d = (alt_i && sel_q) ? pre1_i : pre0_i;
    end else if (step_up) begin
      count_d  = count_q + ONE;
      ovf_d    = (count_q == ALL_ONES);
      hit_zero = (count_q == ALL_ONES);
    end else if (step_dn) begin
      if (alt_i && count_q == ONE) begin
        count_d = sel_q ? pre0_i : pre1_i;
        sel_d   = ~sel_q;
      end else begin
        count_d  = count_q - ONE;
        unf_d    = is_zero;
        hit_zero = (count_q == ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      sel_q   <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      count_q <= count_d;
      sel_q   <= sel_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      zero_q  <= (count_d == '0);
    end
  end

  assign count_o     = count_q;
  assign sel_o       = sel_q;
  assign count_nxt_o = count_d;
  assign sel_nxt_o   = sel_d;
  assign load_ok_o   = load_ok;
  assign hit_zero_o  = hit_zero;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
  assign zero_o      = zero_q;

  AST_OVF_LANDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (count_q == '0)); // R8
  AST_UNF_LANDS_TOP: assert property (@(posedge clk) disable iff (rst)
    unf_q |-> (count_q == ALL_ONES)); // R8
  AST_REFUSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (zero_only_i && load_req_i && count_q != '0 && !en_i) |=> $stable(count_q)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load_req_i) |=> $stable(count_q)); // R6
  AST_SINGLE_REG: assert property (@(posedge clk) disable iff (rst)
    !alt_i |=> !sel_q); // R5
  AST_ALT_NO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (alt_i && en_i && dec_i && !inc_i && !load_req_i && count_q == ONE)
      |=> (sel_q != $past(sel_q))); // R5

endmodule

// File: rtl/tally_out.sv
module tally_out
  import tally_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             inv_i,
  input  logic             snap_i,
  input  logic [WIDTH-1:0] count_nxt_i,
  input  logic             sel_nxt_i,
  output logic             ext_o
);

  logic      raw;
  logic      ext_q;
  out_qual_e mode;

  assign mode = out_qual_e'(mode_i);

  always_comb begin
    case (mode)
      OQ_SNAP:    raw = snap_i;
      OQ_ALTSEL:  raw = sel_nxt_i;
      OQ_NONZERO: raw = (count_nxt_i != '0);
      OQ_ZERO:    raw = (count_nxt_i == '0);
      default:    raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= raw ^ inv_i;
  end

  assign ext_o = ext_q;

  AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0) |=> (ext_q == $past(inv_i))); // R10
  AST_SNAP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd1 && !inv_i && snap_i) |=> ext_q); // R9

endmodule

// File: rtl/tally_channel.sv
module tally_channel #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rev_dir,
  input  logic             pl_zero_only,
  input  logic             alt_en,
  input  logic [2:0]       out_sel,
  input  logic             out_inv,
  input  logic [1:0]       start_sel,
  input  logic [1:0]       stop_sel,
  input  logic [WIDTH-1:0] pre0,
  input  logic [WIDTH-1:0] pre1,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             index_in,
  input  logic             sw_load,
  input  logic             hw_load,
  input  logic             snap,
  output logic [WIDTH-1:0] count,
  output logic             at_zero,
  output logic             wrap_up,
  output logic             wrap_dn,
  output logic             ext_out
);

  logic             idx_rise, idx_fall;
  logic             en;
  logic             inc, dec;
  logic             load_ok, hit_zero;
  logic             sel, sel_nxt;
  logic [WIDTH-1:0] count_nxt;

  assign inc = rev_dir ? cnt_dn : cnt_up;
  assign dec = rev_dir ? cnt_up : cnt_dn;

  tally_edge #(.N(1)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (index_in),
    .rise_o (idx_rise),
    .fall_o (idx_fall)
  );

  tally_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .start_sel_i (start_sel),
    .stop_sel_i  (stop_sel),
    .idx_rise_i  (idx_rise),
    .idx_fall_i  (idx_fall),
    .load_ok_i   (load_ok),
    .hit_zero_i  (hit_zero),
    .en_o        (en)
  );

  tally_core #(.WIDTH(WIDTH)) u_core (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en),
    .inc_i       (inc),
    .dec_i       (dec),
    .load_req_i  (sw_load | hw_load),
    .zero_only_i (pl_zero_only),
    .alt_i       (alt_en),
    .pre0_i      (pre0),
    .pre1_i      (pre1),
    .count_o     (count),
    .sel_o       (sel),
    .count_nxt_o (count_nxt),
    .sel_nxt_o   (sel_nxt),
    .load_ok_o   (load_ok),
    .hit_zero_o  (hit_zero),
    .ovf_o       (wrap_up),
    .unf_o       (wrap_dn),
    .zero_o      (at_zero)
  );

  tally_out #(.WIDTH(WIDTH)) u_out (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (out_sel),
    .inv_i       (out_inv),
    .snap_i      (snap),
    .count_nxt_i (count_nxt),
    .sel_nxt_i   (sel_nxt),
    .ext_o       (ext_out)
  );

  AST_ZERO_FLAG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    at_zero == (count == '0)); // R11
  AST_MODE3_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (out_sel == 3'd3 && !out_inv) |=> (ext_out == (count != '0) || $past(out_sel) != 3'd3)); // R9
  AST_SEL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (!alt_en) |=> !sel); // R5

endmodule

// File: tb/sim_tally_channel.sv
`timescale 1ns/1ps
module sim_tally_channel;

  localparam int W = 4;
  localparam logic [W-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 0, rev_dir = 0, pl_zero_only = 0, alt_en = 0, out_inv = 0;
  logic [2:0] out_sel = 0;
  logic [1:0] start_sel = 0, stop_sel = 0;
  logic [W-1:0] pre0 = 0, pre1 = 0;
  logic cnt_up = 0, cnt_dn = 0, index_in = 0, sw_load = 0, hw_load = 0, snap = 0;
  logic [W-1:0] count;
  logic at_zero, wrap_up, wrap_dn, ext_out;

  always #5 clk = ~clk;

  tally_channel #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .run(run), .rev_dir(rev_dir), .pl_zero_only(pl_zero_only),
    .alt_en(alt_en), .out_sel(out_sel), .out_inv(out_inv), .start_sel(start_sel),
    .stop_sel(stop_sel), .pre0(pre0), .pre1(pre1), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .index_in(index_in), .sw_load(sw_load), .hw_load(hw_load), .snap(snap),
    .count(count), .at_zero(at_zero), .wrap_up(wrap_up), .wrap_dn(wrap_dn),
    .ext_out(ext_out)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference state, built from the requirements
  logic [W-1:0] m_cnt = 0;
  logic m_sel = 0, m_en = 0, m_runq = 0, m_idxq = 0;
  logic e_zero = 1, e_ovf = 0, e_unf = 0, e_ext = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic rise, fall, ok, inc, dec, hz, start, stop, f, ns;
    logic [W-1:0] nc;
    if (rst) begin
      m_cnt = 0; m_sel = 0; m_en = 0; m_runq = 0; m_idxq = 0;
      e_zero = 1; e_ovf = 0; e_unf = 0; e_ext = 0;
      return;
    end
    rise = index_in && !m_idxq;
    fall = !index_in && m_idxq;
    ok   = (sw_load || hw_load) && (!pl_zero_only || m_cnt == 0);
    inc  = rev_dir ? cnt_dn : cnt_up;
    dec  = rev_dir ? cnt_up : cnt_dn;
    nc = m_cnt; ns = alt_en ? m_sel : 1'b0; hz = 0; e_ovf = 0; e_unf = 0;
    if (ok) nc = (alt_en && m_sel) ? pre1 : pre0;
    else if (m_en && inc && !dec) begin
      nc = m_cnt + 1'b1; e_ovf = (m_cnt == TOP); hz = (nc == 0);
    end else if (m_en && dec && !inc) begin
      if (alt_en && m_cnt == 1) begin
        nc = m_sel ? pre0 : pre1; ns = !m_sel;
      end else begin
        nc = m_cnt - 1'b1; e_unf = (m_cnt == 0); hz = (nc == 0);
      end
    end
    start = (start_sel == 1) ? rise : (start_sel == 2) ? ok : (run && !m_runq);
    stop  = (stop_sel == 1) ? fall : (stop_sel == 2) ? hz : 1'b0;
    case (out_sel)
      3'd1: f = snap;
      3'd2: f = ns;
      3'd3: f = (nc != 0);
      3'd4: f = (nc == 0);
      default: f = 1'b0;
    endcase
    e_ext = f ^ out_inv;
    e_zero = (nc == 0);
    m_en = !run ? 1'b0 : stop ? 1'b0 : start ? 1'b1 : m_en;
    m_cnt = nc; m_sel = ns; m_runq = run; m_idxq = index_in;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk("R4 count", 32'(count), 32'(m_cnt));
    chk("R11 at_zero", 32'(at_zero), 32'(e_zero));
    chk("R8 wrap_up", 32'(wrap_up), 32'(e_ovf));
    chk("R8 wrap_dn", 32'(wrap_dn), 32'(e_unf));
    chk("R9 ext_out", 32'(ext_out), 32'(e_ext));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2;
    tick(); tick();
    chk("R1 reset count", 32'(count), 0);
    chk("R1 reset at_zero", 32'(at_zero), 1);
    chk("R1 reset ext_out", 32'(ext_out), 0);
    chk("R1 reset wraps", 32'({wrap_up, wrap_dn}), 0);
    rst = 0;

    // R2 / R3 permission
    run = 1; pl_zero_only = 1; out_sel = 3; pre0 = 9;
    sw_load = 1; tick(); sw_load = 0;
    chk("R2 load at zero", 32'(count), 9);
    pre0 = 4; hw_load = 1; tick(); hw_load = 0;
    chk("R2 refused nonzero", 32'(count), 9);
    pl_zero_only = 0; hw_load = 1; tick(); hw_load = 0;
    chk("R3 load any time", 32'(count), 4);
    chk("R9 mode3 nonzero", 32'(ext_out), 1);
    out_inv = 1; tick();
    chk("R10 inverted", 32'(ext_out), 0);
    out_inv = 0;

    // R5 alternation
    alt_en = 1; out_sel = 2; pre0 = 2; pre1 = 3;
    sw_load = 1; tick(); sw_load = 0;
    chk("R5 first load", 32'(count), 2);
    cnt_dn = 1; tick(); tick(); cnt_dn = 0;
    chk("R5 reload other", 32'(count), 3);
    chk("R5 selector out", 32'(ext_out), 1);

    // R4 reversal and cancel
    rev_dir = 1; cnt_up = 1; tick();
    chk("R4 reversed", 32'(count), 2);
    cnt_dn = 1; tick(); cnt_up = 0; cnt_dn = 0;
    chk("R4 both hold", 32'(count), 2);
    rev_dir = 0; alt_en = 0;

    // R6 index start, R7 index stop
    run = 0; tick(); start_sel = 1; stop_sel = 1; run = 1; cnt_up = 1; tick();
    chk("R6 no start yet", 32'(count), 2);
    index_in = 1; tick(); tick();
    chk("R6 index start", 32'(count), 3);
    index_in = 0; tick(); tick();
    chk("R7 index stop", 32'(count), 4);
    cnt_up = 0;

    // R8 wrap up
    start_sel = 0; stop_sel = 0; run = 0; tick(); run = 1; tick();
    pre0 = TOP; sw_load = 1; tick(); sw_load = 0;
    cnt_up = 1; tick(); cnt_up = 0;
    chk("R8 overflow", 32'(wrap_up), 1);
    tick();
    chk("R8 one cycle", 32'(wrap_up), 0);

    // R7 stop at zero
    stop_sel = 2; pre0 = 2; sw_load = 1; tick(); sw_load = 0;
    cnt_dn = 1; tick(); tick(); tick(); cnt_dn = 0;
    chk("R7 zero stop", 32'(count), 0);

    // near-exhaustive sweep of configurations
    for (int cfg = 0; cfg < 128; cfg++) begin
      start_sel = 2'(cfg); stop_sel = 2'(cfg >> 2);
      pl_zero_only = cfg[4]; alt_en = cfg[5]; rev_dir = cfg[6];
      for (int c = 0; c < 30; c++) begin
        out_sel = 3'(c); out_inv = c[3];
        run = ($urandom % 16) != 0;
        pre0 = W'($urandom % 5); pre1 = W'($urandom % 5);
        cnt_up = ($urandom % 3) == 0; cnt_dn = ($urandom % 2) == 0;
        index_in = ($urandom % 4) == 0;
        sw_load = ($urandom % 9) == 0; hw_load = ($urandom % 11) == 0;
        snap = ($urandom % 3) == 0;
        tick();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule